// File: doc/BRIEF.md
# DMA Request Priority Arbiter

This block decides which peripheral transfer request a shared DMA engine serves next. Every peripheral owns two request lines, one for receive and one for transmit. The arbiter notes each request at the cycle it first appears. It keeps the pending requests in the order they arrived and hands them out one at a time. The current grant is shown as a peripheral index and a direction bit, and it stays in place until the engine pulses `done`.

Requests that arrive in different cycles are served strictly in arrival order. A fixed hardware order is used only to break ties among requests that first appear in the same cycle. In that order every receive request beats every transmit request, and within one direction the lower peripheral index wins. No priority can be configured at runtime.

A request that is already waiting or already granted is not entered a second time. Because of this, the arrival queue needs exactly one slot per request line (2·N slots) and can never overflow.

Top module: `dma_req_arbiter`

## Requirements
- R1: While `rst_n` is low and after its release, `grant_valid` is 0 and nothing is pending; request lines that were high only during reset are never granted.
- R2: Requests that first appear in different cycles are granted in the order they appeared, whatever their direction or index.
- R3: Among same-direction requests that first appear in the same cycle, the lower peripheral index is granted first; `grant_idx` is always below N.
- R4: Among requests that first appear in the same cycle, every receive request (`grant_dir`=0) is granted before any transmit request (`grant_dir`=1).
- R5: A request line held high while its request is pending or granted produces exactly one grant.
- R6: While `grant_valid` is 1 and `done` is 0, `grant_idx` and `grant_dir` hold their values. `grant_valid` falls only after a cycle with `done`=1. If another request is pending at the `done` cycle, the next grant appears in the following cycle.
- R7: A request sampled at clock edge t reaches the queue at t and can be granted at edge t+1 at the earliest. `grant_valid` is 0 whenever nothing is pending or granted.
- R8: When all 2·N request lines appear together, all 2·N requests are granted: receive 0..N-1, then transmit 0..N-1.
- R9: Once a grant completes with `done`, the same request line may be raised again and is queued and granted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_req | input | N_PERIPH | Receive request per peripheral, bit i = peripheral i |
| tx_req | input | N_PERIPH | Transmit request per peripheral, bit i = peripheral i |
| done | input | 1 | Current grant finished; sampled only while grant_valid is 1 |
| grant_valid | output | 1 | A grant is being presented |
| grant_idx | output | $clog2(N_PERIPH) | Peripheral index of the current grant |
| grant_dir | output | 1 | Direction of the current grant: 0 receive, 1 transmit |

## Verification
The assertions check on every cycle that the grant is held stable until `done` and that `grant_valid` never drops without `done`. They also check that a pending request after `done` gives a back-to-back grant, that the output stays idle when nothing is waiting, and that the queue never exceeds 2·N entries. Only the bench scenarios can show that grants come out in the right order: arrival order across cycles, receive-before-transmit and low-index-first within a cycle. The scenarios also cover held request lines yielding a single grant, the two-edge latency from request to grant, and re-queuing after completion.

// File: rtl/dra_pkg.sv
// Shared definitions for the DMA request arbiter.
// Assumes a slot numbering where receive requests occupy slots 0..N-1 and
// transmit requests occupy slots N..2N-1; ascending slot order is the tie-break order.
package dra_pkg;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } dra_dir_e;

endpackage

// File: rtl/dra_arrival.sv
// Arrival detector: keeps one "in flight" mark per request slot and reports
// the slots whose line is high while unmarked (a new arrival this cycle).
// Assumes the caller releases a slot only when its grant completes.
module dra_arrival #(
    parameter int N_PERIPH = 4,
    localparam int SLOT_N  = 2 * N_PERIPH,
    localparam int SLOT_W  = $clog2(SLOT_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PERIPH-1:0] rx_req,
    input  logic [N_PERIPH-1:0] tx_req,
    input  logic              rel_valid,
    input  logic [SLOT_W-1:0] rel_slot,
    output logic [SLOT_N-1:0] new_vec
);

    logic [SLOT_N-1:0] marks;
    logic [SLOT_N-1:0] rel_mask;
    logic [SLOT_N-1:0] line_vec;

    assign line_vec = {tx_req, rx_req};
    assign new_vec  = line_vec & ~marks;

    // One release decoder per slot.
    for (genvar s = 0; s < SLOT_N; s++) begin : g_rel
        assign rel_mask[s] = rel_valid && (rel_slot == SLOT_W'(s));
    end

    // Mark slots as they arrive, unmark them when their grant completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            marks <= '0;
        end else begin
            marks <= (marks | new_vec) & ~rel_mask;
        end
    end

endmodule

// File: rtl/dra_queue.sv
// Arrival-order queue of request slots with multi-entry push.
// All slots pushed in one cycle are appended in ascending slot order after
// the existing entries; one entry may be popped from the head per cycle.
// Assumes each slot is present at most once, so DEPTH entries never overflow.
module dra_queue #(
    parameter int N_PERIPH = 4,
    localparam int DEPTH   = 2 * N_PERIPH,
    localparam int SLOT_W  = $clog2(DEPTH),
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEPTH-1:0]  push_vec,
    input  logic              pop,
    output logic [SLOT_W-1:0] head_slot,
    output logic              empty,
    output logic [CNT_W-1:0]  count
);

    logic [SLOT_W-1:0] ent     [DEPTH];
    logic [SLOT_W-1:0] ent_nxt [DEPTH];
    logic [CNT_W-1:0]  cnt_nxt;

    assign head_slot = ent[0];
    assign empty     = (count == '0);

    // Shift out the head on pop, then append new slots in tie-break order.
    always_comb begin
        cnt_nxt = count;
        for (int i = 0; i < DEPTH; i++) begin
            ent_nxt[i] = ent[i];
        end
        if (pop && !empty) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                ent_nxt[i] = ent[i + 1];
            end
            ent_nxt[DEPTH-1] = '0;
            cnt_nxt = count - 1'b1;
        end
        for (int k = 0; k < DEPTH; k++) begin
            if (push_vec[k] && (cnt_nxt < CNT_W'(DEPTH))) begin
                ent_nxt[cnt_nxt[SLOT_W-1:0]] = SLOT_W'(k);
                cnt_nxt = cnt_nxt + 1'b1;
            end
        end
    end

    // Register the queue contents and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ent[i] <= '0;
            end
        end else begin
            count <= cnt_nxt;
            for (int i = 0; i < DEPTH; i++) begin
                ent[i] <= ent_nxt[i];
            end
        end
    end

endmodule

// File: rtl/dma_req_arbiter.sv
// DMA request arbiter top: serves receive/transmit requests of N peripherals
// in arrival order, tie-breaking same-cycle arrivals receive-first, then by
// ascending index. Holds one grant until done, then moves to the queue head.
// Assumes done is pulsed by the engine only while grant_valid is high.
module dma_req_arbiter #(
    parameter int N_PERIPH = 4,
    localparam int IDX_W   = (N_PERIPH > 1) ? $clog2(N_PERIPH) : 1,
    localparam int SLOT_N  = 2 * N_PERIPH,
    localparam int SLOT_W  = $clog2(SLOT_N),
    localparam int CNT_W   = $clog2(SLOT_N + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_PERIPH-1:0] rx_req,
    input  logic [N_PERIPH-1:0] tx_req,
    input  logic                done,
    output logic                grant_valid,
    output logic [IDX_W-1:0]    grant_idx,
    output logic                grant_dir
);

    import dra_pkg::*;

    logic [SLOT_N-1:0] new_vec;
    logic [SLOT_W-1:0] head_slot;
    logic [SLOT_W-1:0] gslot;
    logic [CNT_W-1:0]  q_count;
    logic              q_empty;
    logic              slot_free;
    logic              q_pop;
    dra_dir_e          gdir;

    assign slot_free = !grant_valid || done;
    assign q_pop     = slot_free && !q_empty;

    dra_arrival #(.N_PERIPH(N_PERIPH)) u_arrival (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_req    (rx_req),
        .tx_req    (tx_req),
        .rel_valid (grant_valid && done),
        .rel_slot  (gslot),
        .new_vec   (new_vec)
    );

    dra_queue #(.N_PERIPH(N_PERIPH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_vec  (new_vec),
        .pop       (q_pop),
        .head_slot (head_slot),
        .empty     (q_empty),
        .count     (q_count)
    );

    // Grant register: reload from the queue head whenever the grant is free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            gslot       <= '0;
        end else if (slot_free) begin
            grant_valid <= !q_empty;
            if (!q_empty) begin
                gslot <= head_slot;
            end
        end
    end

    // Split the granted slot into direction and peripheral index.
    always_comb begin
        if (gslot >= SLOT_W'(N_PERIPH)) begin
            gdir      = DIR_TX;
            grant_idx = IDX_W'(gslot - SLOT_W'(N_PERIPH));
        end else begin
            gdir      = DIR_RX;
            grant_idx = IDX_W'(gslot);
        end
    end

    assign grant_dir = (gdir == DIR_TX);

endmodule

// File: rtl/dra_checker.sv
// Protocol checker for dma_req_arbiter, attached by bind.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module dra_checker #(
    parameter int N_PERIPH = 4,
    localparam int IDX_W   = (N_PERIPH > 1) ? $clog2(N_PERIPH) : 1,
    localparam int CNT_W   = $clog2(2 * N_PERIPH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done,
    input logic             grant_valid,
    input logic [IDX_W-1:0] grant_idx,
    input logic             grant_dir,
    input logic [CNT_W-1:0] q_count,
    input logic             q_empty
);

    // R6: grant held until done
    a_r6_hold_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !done) |=> (grant_valid && $stable(grant_idx) && $stable(grant_dir)));

    // R6: grant_valid only drops after done
    a_r6_drop_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grant_valid) |-> $past(done));

    // R6: back-to-back grant when something is waiting
    a_r6_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && done && !q_empty) |=> grant_valid);

    // R7: no grant when nothing is waiting and the slot is free
    a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (q_empty && (!grant_valid || done)) |=> !grant_valid);

    // R8: queue never holds more than one entry per request line
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(2 * N_PERIPH));

    // R3: granted index is a real peripheral
    a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (32'(grant_idx) < N_PERIPH));

endmodule

bind dma_req_arbiter dra_checker #(.N_PERIPH(N_PERIPH)) u_dra_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (done),
    .grant_valid (grant_valid),
    .grant_idx   (grant_idx),
    .grant_dir   (grant_dir),
    .q_count     (q_count),
    .q_empty     (q_empty)
);

// File: tb/tb_dma_req_arbiter.sv
// Scoreboard bench: the driver task predicts grant order into exp_q, the
// monitor pops it on every grant, compares, and answers with done.
module tb_dma_req_arbiter;

    localparam int N       = 4;
    localparam int CLK_PER = 10;
    localparam int IDX_W   = $clog2(N);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     rx_req = '0;
    logic [N-1:0]     tx_req = '0;
    logic             done = 1'b0;
    logic             grant_valid;
    logic [IDX_W-1:0] grant_idx;
    logic             grant_dir;

    int    checks = 0;
    int    errors = 0;
    int    grants = 0;
    int    hold_len = 0;
    string cur_tag = "R2";
    int    exp_q[$];
    bit    mark[2*N];

    always #(CLK_PER/2) clk = ~clk;

    dma_req_arbiter #(.N_PERIPH(N)) dut (
        .clk(clk), .rst_n(rst_n), .rx_req(rx_req), .tx_req(tx_req),
        .done(done), .grant_valid(grant_valid), .grant_idx(grant_idx),
        .grant_dir(grant_dir)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: apply request lines for one cycle and predict arrivals.
    task automatic drive(input logic [N-1:0] rx, input logic [N-1:0] tx);
        @(negedge clk);
        rx_req = rx;
        tx_req = tx;
        for (int k = 0; k < 2*N; k++) begin
            bit on = (k < N) ? rx[k] : tx[k-N];
            if (on && !mark[k]) begin
                exp_q.push_back(k);
                mark[k] = 1'b1;
            end
        end
    endtask

    task automatic drain();
        @(posedge clk); #2;
        while (exp_q.size() != 0 || grant_valid) begin
            @(posedge clk); #2;
        end
        repeat (3) @(posedge clk);
    endtask

    // Monitor: compare each grant, hold it, then complete it with done.
    initial begin
        int got, exp_slot, snap;
        logic [IDX_W-1:0] g_idx;
        logic g_dir;
        @(posedge clk); #2;
        forever begin
            if (!grant_valid || !rst_n) begin
                @(posedge clk); #2;
            end else begin
                got = int'(grant_dir) * N + int'(grant_idx);
                grants++;
                if (exp_q.size() == 0) begin
                    check({cur_tag, " unexpected grant"}, got, -1);
                end else begin
                    exp_slot = exp_q.pop_front();
                    check({cur_tag, " grant order"}, got, exp_slot);
                end
                g_idx = grant_idx;
                g_dir = grant_dir;
                for (int h = 0; h < hold_len; h++) begin
                    @(posedge clk); #2;
                    check("R6 hold stable", int'({grant_valid, g_dir, g_idx} == {1'b1, grant_dir, grant_idx}), 1);
                end
                snap = exp_q.size();
                done = 1'b1;
                @(posedge clk); #1;
                done = 1'b0;
                mark[got] = 1'b0;
                #1;
                if (snap > 0) check("R6 back-to-back", int'(grant_valid), 1);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int g0;
        // R1: requests raised only during reset are dropped
        rx_req = 4'b0101;
        tx_req = 4'b0010;
        repeat (3) @(posedge clk);
        #2 check("R1 valid in reset", int'(grant_valid), 0);
        @(negedge clk);
        rx_req = '0;
        tx_req = '0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) begin
            @(posedge clk); #2;
            check("R1 idle after reset", int'(grant_valid), 0);
        end

        // R3: same cycle, same direction, low index first
        cur_tag = "R3"; hold_len = 0;
        drive(4'b1011, 4'b0000); drive('0, '0);
        drain();

        // R4: same cycle, receive before transmit
        cur_tag = "R4";
        drive(4'b0100, 4'b0111); drive('0, '0);
        drain();

        // R2: arrival order beats fixed priority
        cur_tag = "R2"; hold_len = 3;
        drive(4'b0000, 4'b1000); drive(4'b0001, 4'b0000);
        drive(4'b0000, 4'b0010); drive('0, '0);
        drain();

        // R5: a held line gives exactly one grant
        cur_tag = "R5"; hold_len = 6; g0 = grants;
        drive(4'b1000, '0); drive(4'b1000, '0); drive(4'b1000, '0); drive(4'b1000, '0);
        drive('0, '0);
        drain();
        check("R5 single grant for held line", grants - g0, 1);

        // R7: latency and idle behaviour
        cur_tag = "R7"; hold_len = 0;
        @(posedge clk); #2;
        check("R7 idle low", int'(grant_valid), 0);
        drive(4'b0100, '0);
        @(posedge clk); #2;
        check("R7 not yet granted", int'(grant_valid), 0);
        rx_req = '0;
        @(posedge clk); #2;
        check("R7 granted second edge", int'(grant_valid), 1);
        check("R7 granted index", int'(grant_idx), 2);
        drain();

        // R8: all lines together fill the queue, all served
        cur_tag = "R8"; hold_len = 2; g0 = grants;
        drive(4'b1111, 4'b1111); drive('0, '0);
        drain();
        check("R8 all requests granted", grants - g0, 2*N);

        // R9: a completed request can be raised again
        cur_tag = "R9"; hold_len = 0; g0 = grants;
        drive(4'b0010, '0); drive('0, '0);
        drain();
        drive(4'b0010, '0); drive('0, '0);
        drain();
        check("R9 re-request granted twice", grants - g0, 2);
        check("R9 idle at end", int'(grant_valid), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule